// File: doc/BRIEF.md
# Grouped GPIO Mode and Data Register Bank

This block controls sixteen general-purpose pins through a small register interface. The pins sit in four uneven groups of 2, 4, 4 and 6: pins 0-1, pins 2-5, pins 6-9 and pins 10-15. Each group has one data register and one configuration register. Inside a register, a pin's slot is its pin number minus the first pin number of its group. In a data register each pin takes one bit at that slot. In a configuration register each pin takes a 4-bit mode field that starts at four times the slot.

Every mode field write is checked against a legality table for that pin. An illegal code leaves that field unchanged, and a sticky error bit records the attempt. The pin drivers follow the stored modes. A pin can drive its data bit, or pass through one of two external function signals. When it does not drive, its input is sampled through a two-flop synchronizer. A read of the data register returns the driven value for a driving pin and the synchronized level for any other pin.

Top module: `gpio_grp_bank`

## Requirements
- R1: After reset, every mode field is input (0x0), every stored data bit is 0, pin_oe and pin_out are all 0, the error bit is 0, and every register reads 0.
- R2: Addresses 0 to 3 are the data registers of groups 0 to 3 (pins 0-1, 2-5, 6-9, 10-15). Addresses 4 to 7 are the configuration registers of the same groups in the same order. Address 8 is status. Each pin's slot is its pin number minus 0, 2, 6 or 10. Any bit above a group's pins, and any other address, reads 0.
- R3: In a configuration register, pin slot k owns bits [4k+3:4k]. A legal code written there takes effect on the write edge and reads back unchanged.
- R4: Codes 0x0 (input) and 0x8 (output) are legal on every pin. 0x2 (receive alternate) is legal only on pins 4 and 5. 0x9 (function A) is legal only on pins 0 to 3. 0xA (function B) is legal only on pins 0 and 1. All other codes are illegal on every pin.
- R5: A field that receives an illegal code keeps its previous mode. The legal fields in the same write still update. Any illegal field sets status bit 0, and that bit stays set.
- R6: Writing status with bit 0 = 1 clears the error bit. Writing status with bit 0 = 0 has no effect.
- R7: pin_oe[i] is 1 exactly when pin i is in mode 0x8, 0x9 or 0xA.
- R8: pin_out[i] follows the mode of pin i. In mode 0x8 it equals the stored data bit, in mode 0x9 it equals fn_a_in[i], in mode 0xA it equals fn_b_in[i], and in all other modes it is 0.
- R9: A read of a data bit returns pin_out[i] when pin i is driving. Otherwise it returns pin_in[i] as seen through two flops, so a new level is visible after the second rising edge. Data writes store all bits of the group whatever the mode.
- R10: alt_rx_out[i] equals the synchronized pin_in[i] when pin i is in mode 0x2, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per rising edge |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Pin input levels |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin output enables |
| fn_a_in | input | 16 | Function A source for each pin |
| fn_b_in | input | 16 | Function B source for each pin |
| alt_rx_out | output | 16 | Synchronized input routed to the receive alternate function |

## Verification
A mode field that decodes to the wrong pin or slot appears at once. The configuration readback on the very next read shows the misplaced nibble, and pin_oe or pin_out for the affected pin is wrong in the cycle after the write edge. A faulty legality table either lets an illegal code through, which changes pin_oe and the readback, or blocks a legal one. In both cases the error bit disagrees in the cycle after the write. A broken synchronizer shows as a data read that returns a stale or early input level two edges after pin_in changes.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
  localparam int NPIN      = 16;
  localparam int NGRP      = 4;
  localparam int MAX_GSIZE = 6;
  localparam int MW        = 4;

  localparam logic [MW-1:0] MD_IN    = 4'h0;
  localparam logic [MW-1:0] MD_RXALT = 4'h2;
  localparam logic [MW-1:0] MD_OUT   = 4'h8;
  localparam logic [MW-1:0] MD_FNA   = 4'h9;
  localparam logic [MW-1:0] MD_FNB   = 4'hA;

  // first pin number of a group; index NGRP gives one past the last pin
  function automatic int grp_base(input int g);
    case (g)
      0:       return 0;
      1:       return 2;
      2:       return 6;
      3:       return 10;
      default: return NPIN;
    endcase
  endfunction

  function automatic int grp_of(input int p);
    int g;
    g = 0;
    for (int k = 1; k < NGRP; k++)
      if (p >= grp_base(k)) g = k;
    return g;
  endfunction

  function automatic int slot_of(input int p);
    return p - grp_base(grp_of(p));
  endfunction

  function automatic logic mode_legal(input int p, input logic [MW-1:0] c);
    case (c)
      MD_IN, MD_OUT: return 1'b1;
      MD_RXALT:      return (p == 4) || (p == 5);
      MD_FNA:        return p < 4;
      MD_FNB:        return p < 2;
      default:       return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_grp_pkg::*;
#(
  parameter int PIN = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [MW-1:0] cfg_code,
  input  logic          dat_we,
  input  logic          dat_bit,
  input  logic          pin_sync,
  input  logic          fn_a,
  input  logic          fn_b,
  output logic [MW-1:0] mode_q,
  output logic          pad_out,
  output logic          pad_oe,
  output logic          rx_alt,
  output logic          rd_bit,
  output logic          rej
);
  logic code_ok;
  logic data_q;

  assign code_ok = mode_legal(PIN, cfg_code);
  assign rej     = cfg_we && !code_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_IN;
      data_q <= 1'b0;
    end else begin
      if (cfg_we && code_ok) mode_q <= cfg_code;
      if (dat_we)            data_q <= dat_bit;
    end
  end

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    case (mode_q)
      MD_OUT: begin pad_out = data_q; pad_oe = 1'b1; end
      MD_FNA: begin pad_out = fn_a;   pad_oe = 1'b1; end
      MD_FNB: begin pad_out = fn_b;   pad_oe = 1'b1; end
      default: ;
    endcase
  end

  assign rx_alt = (mode_q == MD_RXALT) && pin_sync;
  assign rd_bit = pad_oe ? pad_out : pin_sync;

  // R5
  illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> $stable(mode_q));

  // R4
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_legal(PIN, mode_q));

  // R3
  legal_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !rej) |=> (mode_q == $past(cfg_code)));
endmodule

// File: rtl/gpio_grp_bank.sv
module gpio_grp_bank
  import gpio_grp_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic [NPIN-1:0] fn_a_in,
  input  logic [NPIN-1:0] fn_b_in,
  output logic [NPIN-1:0] alt_rx_out
);
  localparam int          USED_W    = MW * MAX_GSIZE;
  localparam logic [AW-1:0] STAT_ADDR = AW'(2 * NGRP);

  logic [NGRP-1:0]         dat_hit, cfg_hit;
  logic [NPIN-1:0]         pin_sync, rd_bits, rej_vec;
  logic [NPIN-1:0][MW-1:0] modes;
  logic [DW-1:0]           dat_part [NPIN];
  logic [DW-1:0]           cfg_part [NPIN];
  logic                    stat_hit, err_clr, err_q;
  logic                    unused_wdata;

  assign unused_wdata = ^bus_wdata[DW-1:USED_W];

  for (genvar g = 0; g < NGRP; g++) begin : g_dec
    assign dat_hit[g] = (bus_addr == AW'(g));
    assign cfg_hit[g] = (bus_addr == AW'(NGRP + g));
  end
  assign stat_hit = (bus_addr == STAT_ADDR);
  assign err_clr  = bus_we && stat_hit && bus_wdata[0];

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam int G   = grp_of(i);
    localparam int REL = slot_of(i);

    gpio_pin_cell #(.PIN(i)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (bus_we && cfg_hit[G]),
      .cfg_code (bus_wdata[MW*REL +: MW]),
      .dat_we   (bus_we && dat_hit[G]),
      .dat_bit  (bus_wdata[REL]),
      .pin_sync (pin_sync[i]),
      .fn_a     (fn_a_in[i]),
      .fn_b     (fn_b_in[i]),
      .mode_q   (modes[i]),
      .pad_out  (pin_out[i]),
      .pad_oe   (pin_oe[i]),
      .rx_alt   (alt_rx_out[i]),
      .rd_bit   (rd_bits[i]),
      .rej      (rej_vec[i])
    );

    assign dat_part[i] = dat_hit[G] ? ({{(DW-1){1'b0}}, rd_bits[i]} << REL) : '0;
    assign cfg_part[i] = cfg_hit[G] ? ({{(DW-MW){1'b0}}, modes[i]} << (MW*REL)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (err_q && !err_clr) || (|rej_vec);
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NPIN; i++)
      bus_rdata = bus_rdata | dat_part[i] | cfg_part[i];
    if (stat_hit) bus_rdata[0] = err_q;
  end

  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rej_vec) |=> err_q);

  // R6
  err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(err_clr));

  // R7
  oe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_out & ~pin_oe) == 0);
endmodule

// File: tb/sim_gpio_grp_bank.sv
`timescale 1ns/1ps
module sim_gpio_grp_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0, fn_a_in = '0, fn_b_in = '0;
  logic [15:0] pin_out, pin_oe, alt_rx_out;

  int checks = 0, fails = 0;
  logic [3:0] m_mode [16];
  logic       m_dat  [16];
  logic       m_err;

  always #2 clk = ~clk;

  gpio_grp_bank u0 (.*);

  function automatic int b_base(input int p);
    if (p < 2) return 0;
    if (p < 6) return 2;
    if (p < 10) return 6;
    return 10;
  endfunction

  function automatic int b_grp(input int p);
    return (p < 2) ? 0 : (p < 6) ? 1 : (p < 10) ? 2 : 3;
  endfunction

  function automatic logic b_legal(input int p, input logic [3:0] c);
    logic [15:0] mask;
    case (c)
      4'h0, 4'h8: mask = 16'hFFFF;
      4'h2:       mask = 16'h0030;
      4'h9:       mask = 16'h000F;
      4'hA:       mask = 16'h0003;
      default:    mask = 16'h0000;
    endcase
    return mask[p];
  endfunction

  function automatic logic b_oe(input int p);
    return m_mode[p] == 4'h8 || m_mode[p] == 4'h9 || m_mode[p] == 4'hA;
  endfunction

  function automatic logic b_out(input int p);
    case (m_mode[p])
      4'h8: return m_dat[p];
      4'h9: return fn_a_in[p];
      4'hA: return fn_b_in[p];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] b_reg(input int a);
    logic [31:0] r;
    r = '0;
    for (int p = 0; p < 16; p++) begin
      if (a == b_grp(p))
        r[p - b_base(p)] = b_oe(p) ? b_out(p) : pin_in[p];
      if (a == 4 + b_grp(p))
        r[4*(p - b_base(p)) +: 4] = m_mode[p];
    end
    if (a == 8) r[0] = m_err;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a < 4) begin
      for (int p = 0; p < 16; p++)
        if (b_grp(p) == a) m_dat[p] = d[p - b_base(p)];
    end else if (a < 8) begin
      for (int p = 0; p < 16; p++)
        if (b_grp(p) == a - 4) begin
          if (b_legal(p, d[4*(p - b_base(p)) +: 4])) m_mode[p] = d[4*(p - b_base(p)) +: 4];
          else m_err = 1'b1;
        end
    end else if (a == 8 && d[0]) m_err = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [15:0] eoe, eout, erx;
    for (int a = 0; a < 10; a++) begin
      bus_addr = 4'(a);
      #0.5;
      chk($sformatf("%s R2 R3 R9 R5 reg%0d", tag, a), bus_rdata, b_reg(a));
    end
    for (int p = 0; p < 16; p++) begin
      eoe[p]  = b_oe(p);
      eout[p] = b_out(p);
      erx[p]  = (m_mode[p] == 4'h2) && pin_in[p];
    end
    chk({tag, " R7 pin_oe"}, 32'(pin_oe), 32'(eoe));
    chk({tag, " R8 pin_out"}, 32'(pin_out), 32'(eout));
    chk({tag, " R10 alt_rx"}, 32'(alt_rx_out), 32'(erx));
  endtask

  function automatic logic [3:0] pick_code();
    int r;
    r = $urandom_range(0, 9);
    case (r)
      0, 1: return 4'h0;
      2, 3: return 4'h8;
      4: return 4'h2;
      5: return 4'h9;
      6: return 4'hA;
      default: return 4'($urandom_range(0, 15));
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5EED_0017));
    for (int p = 0; p < 16; p++) begin m_mode[p] = 4'h0; m_dat[p] = 1'b0; end
    m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_all("R1 reset");

    // R3 R4 legal function modes on pins 0,1
    fn_a_in = 16'h0001; fn_b_in = 16'h0002;
    wr(4, 32'h0000_00A9);
    settle();
    check_all("R3 R4 grp0 fn");

    // R5 mixed legal/illegal in group 1: pin2<-2 bad, pin3<-8, pin4<-2, pin5<-A bad
    wr(5, 32'h0000_A282);
    settle();
    chk("R5 grp1 readback", b_reg(5), 32'h0000_0280);
    check_all("R5 mixed");

    // R6 status write 0 keeps, 1 clears
    wr(8, 32'h0000_0000);
    settle();
    check_all("R6 no clear");
    wr(8, 32'h0000_0001);
    settle();
    check_all("R6 clear");

    // R4 reserved code on pin 10 rejected, data bits beyond group ignored
    wr(7, 32'h00FF_FFFB);
    settle();
    check_all("R4 reserved");
    wr(3, 32'hFFFF_FFFF);
    settle();
    check_all("R9 R8 grp3 data");

    // R9 input sampling in input mode
    pin_in = 16'hA5C3;
    settle();
    check_all("R9 sync");

    for (int n = 0; n < 400; n++) begin
      case ($urandom_range(0, 4))
        0, 1: begin
          int g;
          g = $urandom_range(0, 3);
          w = '0;
          for (int k = 0; k < 6; k++) w[4*k +: 4] = pick_code();
          w[31:24] = 8'($urandom);
          wr(4 + g, w);
        end
        2: wr($urandom_range(0, 3), $urandom);
        3: wr($urandom_range(8, 9), 32'($urandom_range(0, 1)));
        default: begin
          @(negedge clk);
          pin_in = 16'($urandom); fn_a_in = 16'($urandom); fn_b_in = 16'($urandom);
        end
      endcase
      settle();
      check_all($sformatf("rand%0d", n));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule